// File: doc/BRIEF.md
# Delayed-Parity Error Checker

This block guards a registered address/command word with even parity whose check bit arrives one clock after the word it covers. Each cycle it reduces the checked lanes of the incoming word to one bit and holds that bit in a short delay line. On the following edge it combines the bit with the late parity bit. A mismatch drives an active-low error flag. The flag then stays low for a fixed number of cycles, and a fresh mismatch restarts that hold. A low-power input freezes the flag.

The checker can run alone, or it can be split across two devices that each see half of a wider word. The first device of a pair does not flag errors. It exports its partial parity (its own lanes XOR the incoming parity bit), and that output feeds the parity input of the second device. The second device delays its own lane parity by one extra stage, so that it meets the upstream partial parity. It then raises the error and its partial-parity output two cycles after the word was registered. Four control lanes at the top of the word are left out of the check.

Top module: `addr_par_check`

## Requirements
- R1: In single role (pair_i=0), a word sampled at edge n is checked against par_i sampled at edge n+1. The check is even parity over data_i bits 11:0 and par_i. If the XOR is odd, err_no is low after edge n+1; if it is even, no error is started.
- R2: Bits 15:12 of data_i (the control lanes) never take part in the parity, the error decision or ppo_o.
- R3: Once an error is captured, err_no stays low for exactly 2 clock cycles and then returns high, provided no further error arrives and lp_i stays low.
- R4: A new error captured while err_no is already low restarts the 2-cycle hold, counted from the new error.
- R5: rst_ni low (asynchronous) forces err_no high and ppo_o low at once, including in the middle of a hold.
- R6: When lp_i is high at a clock edge, err_no does not change at that edge. A hold in progress pauses, and any error checked at that edge is dropped.
- R7: In single and first roles, ppo_o after edge n+1 equals XOR(data_i[11:0] at edge n) XOR par_i at edge n+1.
- R8: In second role (pair_i=1, second_i=1), the block's own lanes from edge n are combined with par_i sampled at edge n+2 (the first device's ppo_o). ppo_o and err_no reflect that result after edge n+2.
- R9: In first role (pair_i=1, second_i=0), err_no stays high whatever parity arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 16 | Registered address/command word; bits 15:12 are control lanes |
| par_i | input | 1 | Parity bit of the previous cycle's word, or the upstream partial parity in second role |
| lp_i | input | 1 | Low-power gate; freezes the error flag |
| pair_i | input | 1 | 0: single device, 1: one of a cascaded pair |
| second_i | input | 1 | In a pair: 0 first device, 1 second device |
| ppo_o | output | 1 | Partial parity out |
| err_no | output | 1 | Error flag, active low |

## Verification
The assertions assume that pair_i and second_i change only while rst_ni is low. They also assume that par_i always belongs to the word sampled one edge earlier, or, in second role, that it is the first device's ppo_o. The bench therefore sets the role pins only under reset. It recomputes the parity bit for every word from the previous word it drove, flipping it only on rows marked as error injections. For the cascade it feeds the second instance straight from the first instance's ppo_o, so the two-stage alignment those properties rely on is always present.

// File: rtl/addr_par_pkg.sv
package addr_par_pkg;
  typedef enum logic [1:0] {
    ROLE_SINGLE = 2'd0,
    ROLE_FIRST  = 2'd1,
    ROLE_SECOND = 2'd2
  } role_e;

  function automatic role_e decode_role(input logic pair, input logic second);
    if (!pair) return ROLE_SINGLE;
    return second ? ROLE_SECOND : ROLE_FIRST;
  endfunction
endpackage

// File: rtl/apc_lane_parity.sv
module apc_lane_parity #(
  parameter int unsigned DW = 16,
  parameter logic [DW-1:0] MASK = '1
) (
  input  logic [DW-1:0] data_i,
  output logic          par_o
);
  always_comb begin
    par_o = 1'b0;
    for (int i = 0; i < DW; i++) par_o = par_o ^ (data_i[i] & MASK[i]);
  end
endmodule

// File: rtl/apc_par_delay.sv
module apc_par_delay #(
  parameter int unsigned DEPTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_i,
  output logic [DEPTH-1:0] tap_o
);
  logic [DEPTH-1:0] stg_q;

  for (genvar k = 0; k < DEPTH; k++) begin : g_stage
    if (k == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[k] <= 1'b0;
        else         stg_q[k] <= bit_i;
    end else begin : g_tail
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[k] <= 1'b0;
        else         stg_q[k] <= stg_q[k-1];
    end
  end

  assign tap_o = stg_q;
endmodule

// File: rtl/apc_err_hold.sv
module apc_err_hold #(
  parameter int unsigned HOLD = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic freeze_i,
  output logic err_no
);
  localparam int unsigned CW = $clog2(HOLD + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!freeze_i) begin
      if (hit_i)              cnt_q <= CW'(HOLD);
      else if (cnt_q != '0)   cnt_q <= cnt_q - CW'(1);
    end
  end

  assign err_no = (cnt_q == '0);
endmodule

// File: rtl/addr_par_check.sv
module addr_par_check
  import addr_par_pkg::*;
#(
  parameter int unsigned     DW          = 16,
  parameter logic [DW-1:0]   CHK_MASK    = 16'h0FFF,
  parameter int unsigned     HOLD_CYCLES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] data_i,
  input  logic          par_i,
  input  logic          lp_i,
  input  logic          pair_i,
  input  logic          second_i,
  output logic          ppo_o,
  output logic          err_no
);
  // stage 0 serves single/first, stage 1 lines up with an upstream ppo
  localparam int unsigned DLY = 2;

  role_e          role;
  logic           word_par;
  logic [DLY-1:0] taps;
  logic           tap_sel;
  logic           sum;
  logic           hit;
  logic           ppo_q;

  assign role = decode_role(pair_i, second_i);

  apc_lane_parity #(.DW(DW), .MASK(CHK_MASK)) u_lane_par (
    .data_i (data_i),
    .par_o  (word_par)
  );

  apc_par_delay #(.DEPTH(DLY)) u_delay (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .bit_i  (word_par),
    .tap_o  (taps)
  );

  assign tap_sel = (role == ROLE_SECOND) ? taps[DLY-1] : taps[0];
  assign sum     = tap_sel ^ par_i;
  assign hit     = sum & (role != ROLE_FIRST);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) ppo_q <= 1'b0;
    else         ppo_q <= sum;

  assign ppo_o = ppo_q;

  apc_err_hold #(.HOLD(HOLD_CYCLES)) u_hold (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hit_i    (hit),
    .freeze_i (lp_i),
    .err_no   (err_no)
  );
endmodule

// File: rtl/apc_checker.sv
module apc_checker #(
  parameter int unsigned   DW       = 16,
  parameter logic [DW-1:0] CHK_MASK = 16'h0FFF
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [DW-1:0] data_i,
  input logic          par_i,
  input logic          lp_i,
  input logic          pair_i,
  input logic          second_i,
  input logic          ppo_o,
  input logic          err_no
);
  logic [2:0] warm_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)            warm_q <= '0;
    else if (warm_q != 3'd4) warm_q <= warm_q + 3'd1;

  AST_RST_FORCE: assert property (@(posedge clk_i)
    !rst_ni |-> (err_no && !ppo_o)); // R5

  AST_ERR_ON_MISMATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q >= 3'd2 && !pair_i && !lp_i && (par_i ^ (^($past(data_i) & CHK_MASK))))
    |=> !err_no); // R1

  AST_MIN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(err_no) |=> !err_no); // R3

  AST_LP_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lp_i |=> $stable(err_no)); // R6

  AST_FIRST_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pair_i && !second_i) |-> err_no); // R9

  AST_PPO_NEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q >= 3'd3 && !(pair_i && second_i))
    |-> ppo_o == ($past(par_i) ^ (^($past(data_i, 2) & CHK_MASK)))); // R7

  AST_PPO_FAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 3'd4 && pair_i && second_i)
    |-> ppo_o == ($past(par_i) ^ (^($past(data_i, 3) & CHK_MASK)))); // R8
endmodule

bind addr_par_check apc_checker #(.DW(DW), .CHK_MASK(CHK_MASK)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .data_i   (data_i),
  .par_i    (par_i),
  .lp_i     (lp_i),
  .pair_i   (pair_i),
  .second_i (second_i),
  .ppo_o    (ppo_o),
  .err_no   (err_no)
);

// File: tb/test_addr_par_check.sv
module test_addr_par_check;
  localparam logic [15:0] MASK = 16'h0FFF;
  localparam int NVEC = 18;

  typedef struct packed {
    logic [15:0] d;
    logic        flip;
    logic        lp;
    logic        exp_err_n;
    logic        exp_ppo;
  } vec_t;

  // err_n / ppo expected after the edge that samples this row
  localparam vec_t VEC [NVEC] = '{
    '{16'h1234, 1'b0, 1'b0, 1'b1, 1'b0},
    '{16'hF00F, 1'b1, 1'b0, 1'b1, 1'b0},
    '{16'h0001, 1'b0, 1'b0, 1'b0, 1'b1},
    '{16'hABCD, 1'b0, 1'b0, 1'b0, 1'b0},
    '{16'h8000, 1'b0, 1'b0, 1'b1, 1'b0},
    '{16'h7FFE, 1'b1, 1'b0, 1'b1, 1'b0},
    '{16'h00FF, 1'b1, 1'b0, 1'b0, 1'b1},
    '{16'h5A5A, 1'b0, 1'b0, 1'b0, 1'b1},
    '{16'hC3C3, 1'b0, 1'b0, 1'b0, 1'b0},
    '{16'h0F0F, 1'b0, 1'b0, 1'b1, 1'b0},
    '{16'h3333, 1'b1, 1'b0, 1'b1, 1'b0},
    '{16'hFFFF, 1'b0, 1'b1, 1'b1, 1'b1},
    '{16'h1111, 1'b1, 1'b0, 1'b1, 1'b0},
    '{16'h2222, 1'b0, 1'b0, 1'b0, 1'b1},
    '{16'h4444, 1'b0, 1'b1, 1'b0, 1'b0},
    '{16'h8888, 1'b0, 1'b1, 1'b0, 1'b0},
    '{16'h0000, 1'b0, 1'b0, 1'b0, 1'b0},
    '{16'hE001, 1'b0, 1'b0, 1'b1, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] data_a = '0, data_b = '0;
  logic        par_a = 1'b0, lp_a = 1'b0;
  logic        pair_a = 1'b0, second_a = 1'b0;
  logic        ppo_a, err_a, ppo_b, err_b;
  int          n_chk = 0, n_bad = 0, cyc = 0;

  always #2 clk = ~clk;

  addr_par_check i_addr_par_check (
    .clk_i (clk), .rst_ni (rst_n), .data_i (data_a), .par_i (par_a),
    .lp_i (lp_a), .pair_i (pair_a), .second_i (second_a),
    .ppo_o (ppo_a), .err_no (err_a)
  );

  addr_par_check i_addr_par_check_sec (
    .clk_i (clk), .rst_ni (rst_n), .data_i (data_b), .par_i (ppo_a),
    .lp_i (1'b0), .pair_i (1'b1), .second_i (1'b1),
    .ppo_o (ppo_b), .err_no (err_b)
  );

  function automatic logic mpar(input logic [15:0] d);
    return ^(d & MASK);
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset(input logic pair, input logic second);
    @(negedge clk);
    rst_n = 1'b0; data_a = '0; data_b = '0; par_a = 1'b0; lp_a = 1'b0;
    pair_a = pair; second_a = second;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // reset state R5
    @(negedge clk);
    chk("R5 reset err_no", err_a, 1'b1);
    chk("R5 reset ppo", ppo_a, 1'b0);
    rst_n = 1'b1;

    // table walk, single role: R1 R3 R4 R6 R7
    for (int i = 0; i < NVEC; i++) begin
      data_a = VEC[i].d;
      par_a  = (i == 0) ? 1'b0 : (mpar(VEC[i-1].d) ^ VEC[i-1].flip);
      lp_a   = VEC[i].lp;
      @(posedge clk);
      @(negedge clk);
      chk("R1/R3/R4/R6 err_no", err_a, VEC[i].exp_err_n);
      chk("R7 ppo", ppo_a, VEC[i].exp_ppo);
    end

    // R2: odd control-lane bits with parity from checked lanes only
    data_a = 16'h1000; par_a = mpar(VEC[NVEC-1].d); lp_a = 1'b0;
    @(negedge clk);
    data_a = 16'h7005; par_a = mpar(16'h1000);
    @(negedge clk);
    chk("R2 excluded lanes err_no", err_a, 1'b1);
    chk("R2 excluded lanes ppo", ppo_a, 1'b0);
    data_a = 16'h0000; par_a = mpar(16'h7005);
    @(negedge clk);
    chk("R2 excluded lanes err_no", err_a, 1'b1);
    chk("R2 excluded lanes ppo", ppo_a, 1'b0);

    // R5: async reset in the middle of a hold
    data_a = 16'h0003; par_a = 1'b0;
    @(negedge clk);
    data_a = 16'h0000; par_a = mpar(16'h0003) ^ 1'b1;
    @(negedge clk);
    chk("R1 error raised", err_a, 1'b0);
    chk("R5 ppo before reset", ppo_a, 1'b1);
    #1 rst_n = 1'b0;
    #0.5;
    chk("R5 async err_no", err_a, 1'b1);
    chk("R5 async ppo", ppo_a, 1'b0);

    // R9 + R7: first role never flags, ppo still computed
    do_reset(1'b1, 1'b0);
    data_a = 16'h0007;
    @(negedge clk);
    data_a = 16'h0000; par_a = mpar(16'h0007) ^ 1'b1;
    @(negedge clk);
    chk("R9 first role err_no", err_a, 1'b1);
    chk("R7 first role ppo", ppo_a, 1'b1);
    par_a = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R9 first role err_no", err_a, 1'b1);
    end

    // R8: cascade, error injected on row 2
    do_reset(1'b1, 1'b0);
    begin
      logic [15:0] pa, pb;
      logic pf;
      pa = '0; pb = '0; pf = 1'b0;
      for (int i = 0; i < 8; i++) begin
        data_a = 16'h1357 * 16'(i + 1);
        data_b = 16'h2468 ^ 16'(i * 16'h0111);
        par_a  = (i == 0) ? 1'b0 : (mpar(pa) ^ mpar(pb) ^ pf);
        pa = data_a; pb = data_b; pf = (i == 2);
        @(posedge clk);
        @(negedge clk);
        chk("R8 second err_no", err_b, !(i == 4 || i == 5));
        chk("R8 second ppo", ppo_b, (i == 4));
        chk("R9 first err_no in pair", err_a, 1'b1);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule